// File: doc/BRIEF.md
# Page Write Load Controller

This block sits in front of a byte-wide nonvolatile storage array. It gathers a burst of host writes that all target one page into a 64-byte page buffer, with one valid flag for each byte. The host can keep adding bytes as long as each one arrives within a byte-load window that is measured from the previous accepted write. When the window runs out, the block stops taking data and starts a timed program phase. In that phase only the flagged bytes are copied into the array. Every other byte of the page keeps its old contents.

The 15-bit host address is split into two parts. The low 6 bits choose the byte within the page, and the upper 9 bits choose the page. The first write of a load latches the page. During the load, a write to any other page is dropped. `busy` goes high on the first accepted write and stays high until the program phase ends. While `busy` is high, every new write is refused. The load window and the program time are both counted in clock cycles, so they can be set to real-time values on silicon and to short values in simulation.

The array stores `ARR_PAGES` pages and comes up fully erased (every byte 0xFF) out of reset. A read port returns the contents of the array combinationally.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy` is 0 and every array location reads 0xFF.
- R2: In idle, a write strobe is accepted. `busy` reads 1 from the clock edge that samples the strobe.
- R3: A write sampled up to `LOAD_WIN` cycles after the previous accepted write, with the same page bits (address bits 14:6), is added to the load and restarts the window.
- R4: If `LOAD_WIN` cycles pass with no accepted write, the program phase starts. `busy` then stays high for `PROG_CYC` more cycles, so a load with one write keeps `busy` high for `LOAD_WIN + PROG_CYC` cycles.
- R5: During a load, a write whose page bits differ from the latched page is ignored. It neither stores data nor restarts the window.
- R6: Bytes may arrive in any offset order (address bits 5:0). A byte written twice in one load takes the last value.
- R7: At the end of the program phase, exactly the loaded bytes hold their new values. All other locations are unchanged.
- R8: Writes sampled during the program phase are ignored.
- R9: The array location is the page number modulo `ARR_PAGES`, concatenated with the offset. Reads use the same mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle for each byte |
| wr_addr | input | ADDR_W | Write address: page bits above, byte offset below |
| wr_data | input | DATA_W | Write byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array contents at `rd_addr` |
| busy | output | 1 | High from the first accepted write until programming completes |

## Verification
The bound assertions check the following on every cycle: `busy` rises only after a strobe, `busy` falls only out of the program phase, and the array is written only in the program phase. They also check that a load always holds at least one flagged byte, that a stray-page write lets the window counter keep running, and that strobes during programming leave the flags untouched. The exact window boundary can only be shown by the bench scenarios together with its reference model. Those scenarios cover a gap of exactly `LOAD_WIN` against one cycle more, the overall length of `busy`, overwrites, out-of-order loading, preservation of unloaded bytes, and page aliasing in the array.

// File: rtl/plc_pkg.sv
package plc_pkg;
    typedef enum logic [1:0] {
        PLC_IDLE = 2'd0,
        PLC_LOAD = 2'd1,
        PLC_PROG = 2'd2
    } plc_state_e;
endpackage

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
    parameter int OFS_W  = 6,
    parameter int DATA_W = 8,
    localparam int NBYTES = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [OFS_W-1:0]  wofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFS_W-1:0]  rofs,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [NBYTES-1:0] valid
);
    logic [DATA_W-1:0] bytes_q [NBYTES];
    logic [NBYTES-1:0] valid_q;

    // flags: clear wins over a new write (never both in one cycle)
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[wofs] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            bytes_q[wofs] <= wdata;
        end
    end

    assign rdata  = bytes_q[rofs];
    assign rvalid = valid_q[rofs];
    assign valid  = valid_q;
endmodule

// File: rtl/plc_store.sv
module plc_store #(
    parameter int AW     = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 6,
    parameter int ARR_PAGES = 8,
    parameter int LOAD_WIN  = 7500,
    parameter int PROG_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int ARR_PW     = $clog2(ARR_PAGES);
    localparam int ARR_AW     = ARR_PW + OFS_W;
    localparam int WIN_W      = $clog2(LOAD_WIN);
    localparam int PRG_W      = $clog2(PROG_CYC) + 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WIN - 1);
    localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);
    localparam logic [PRG_W-1:0] SCAN_END = PRG_W'(PAGE_BYTES);

    typedef struct packed {
        plc_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [WIN_W-1:0]  win;
        logic [PRG_W-1:0]  prog;
        logic              busy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PAGE_W-1:0]     wr_page;
    logic [OFS_W-1:0]      wr_ofs;
    logic                  page_hit;
    logic                  buf_we, buf_clr, st_we;
    logic [OFS_W-1:0]      scan_ofs;
    logic [DATA_W-1:0]     scan_data;
    logic                  scan_valid;
    logic [PAGE_BYTES-1:0] valid_vec;
    logic [ARR_AW-1:0]     st_waddr;
    plc_state_e            cur_state;
    logic [WIN_W-1:0]      win_cnt;

    assign wr_page   = wr_addr[ADDR_W-1:OFS_W];
    assign wr_ofs    = wr_addr[OFS_W-1:0];
    assign page_hit  = (wr_page == ctl_q.page);
    assign scan_ofs  = ctl_q.prog[OFS_W-1:0];
    assign st_waddr  = {ctl_q.page[ARR_PW-1:0], scan_ofs};
    assign cur_state = ctl_q.state;
    assign win_cnt   = ctl_q.win;

    always_comb begin
        ctl_d   = ctl_q;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        st_we   = 1'b0;
        unique case (ctl_q.state)
            PLC_IDLE: begin
                if (wr_en) begin
                    ctl_d.state = PLC_LOAD;
                    ctl_d.page  = wr_page;
                    ctl_d.win   = '0;
                    ctl_d.busy  = 1'b1;
                    buf_we      = 1'b1;
                end
            end
            PLC_LOAD: begin
                if (wr_en && page_hit) begin
                    buf_we    = 1'b1;
                    ctl_d.win = '0;
                end else if (ctl_q.win == WIN_LAST) begin
                    ctl_d.state = PLC_PROG;
                    ctl_d.prog  = '0;
                end else begin
                    ctl_d.win = ctl_q.win + 1'b1;
                end
            end
            PLC_PROG: begin
                // one offset per cycle during the first PAGE_BYTES cycles
                st_we = (ctl_q.prog < SCAN_END) && scan_valid;
                if (ctl_q.prog == PRG_LAST) begin
                    ctl_d.state = PLC_IDLE;
                    ctl_d.busy  = 1'b0;
                    buf_clr     = 1'b1;
                end else begin
                    ctl_d.prog = ctl_q.prog + 1'b1;
                end
            end
            default: begin
                ctl_d.state = PLC_IDLE;
                ctl_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: PLC_IDLE, page: '0, win: '0, prog: '0, busy: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    plc_page_buf #(
        .OFS_W (OFS_W),
        .DATA_W(DATA_W)
    ) pbuf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .wofs  (wr_ofs),
        .wdata (wr_data),
        .rofs  (scan_ofs),
        .rdata (scan_data),
        .rvalid(scan_valid),
        .valid (valid_vec)
    );

    plc_store #(
        .AW    (ARR_AW),
        .DATA_W(DATA_W)
    ) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .waddr(st_waddr),
        .wdata(scan_data),
        .raddr(rd_addr[ARR_AW-1:0]),
        .rdata(rd_data)
    );

    logic unused_rd_hi;
    assign unused_rd_hi = ^rd_addr[ADDR_W-1:ARR_AW];

    assign busy = ctl_q.busy;
endmodule

// File: rtl/plc_chk.sv
module plc_chk
    import plc_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int OFS_W    = 6,
    localparam int WIN_W   = $clog2(LOAD_WIN),
    localparam int NBYTES  = 1 << OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic              page_hit,
    input logic              st_we,
    input plc_state_e        cur_state,
    input logic [WIN_W-1:0]  win_cnt,
    input logic [NBYTES-1:0] valid_vec
);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOAD_WIN - 1);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cur_state) == PLC_PROG);

    // R5
    stray_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == PLC_LOAD && wr_en && !page_hit && win_cnt != WIN_LAST)
        |=> win_cnt == $past(win_cnt) + 1'b1);

    // R7
    commit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> cur_state == PLC_PROG);

    // R3
    load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == PLC_LOAD |-> $countones(valid_vec) > 0);

    // R8
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == PLC_PROG && wr_en) |=> ($stable(valid_vec) || valid_vec == '0));
endmodule

bind page_load_ctrl plc_chk #(
    .LOAD_WIN(LOAD_WIN),
    .OFS_W   (OFS_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (busy),
    .page_hit (page_hit),
    .st_we    (st_we),
    .cur_state(cur_state),
    .win_cnt  (win_cnt),
    .valid_vec(valid_vec)
);

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW    = 8;
    localparam int PC    = 80;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [14:0] rd_addr;
    logic [7:0]  rd_data;
    logic        busy;

    logic        rd_hold = 1'b0;
    logic [14:0] rd_sel = '0;
    logic [14:0] sweep = '0;
    assign rd_addr = rd_hold ? rd_sel : sweep;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_load_ctrl #(
        .LOAD_WIN(LW),
        .PROG_CYC(PC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // behavioural reference model
    int         m_mode = 0;
    int         m_cnt  = 0;
    int         m_page = 0;
    bit         m_busy = 1'b0;
    logic [7:0] m_mem [DEPTH];
    logic [7:0] pend [int];

    always @(posedge clk) begin
        sweep <= sweep + 15'd1;
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_busy = 1'b0; pend.delete();
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
        end else begin
            case (m_mode)
                0: if (wr_en) begin
                    m_page = int'(wr_addr) / 64;
                    pend.delete();
                    pend[int'(wr_addr) % 64] = wr_data;
                    m_mode = 1; m_cnt = 0; m_busy = 1'b1;
                end
                1: if (wr_en && int'(wr_addr) / 64 == m_page) begin
                    pend[int'(wr_addr) % 64] = wr_data;
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == LW) begin m_mode = 2; m_cnt = 0; end
                end
                default: begin
                    m_cnt++;
                    if (m_cnt == PC) begin
                        foreach (pend[o]) m_mem[(m_page * 64 + o) % DEPTH] = pend[o];
                        m_mode = 0; m_busy = 1'b0;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (busy !== m_busy) begin
                fails++;
                $display("FAIL R4 model busy: actual=%0b expected=%0b t=%0t", busy, m_busy, $time);
            end
            if (!m_busy) begin
                checks++;
                if (rd_data !== m_mem[int'(rd_addr) % DEPTH]) begin
                    fails++;
                    $display("FAIL R7 model read @%h: actual=%h expected=%h", rd_addr, rd_data,
                             m_mem[int'(rd_addr) % DEPTH]);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int addr, input int data);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = 15'(addr); wr_data = 8'(data);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        @(negedge clk);
        while (busy === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd_chk(input string tag, input int addr, input int exp);
        @(posedge clk); #2;
        rd_hold = 1'b1; rd_sel = 15'(addr);
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
        @(posedge clk); #2;
        rd_hold = 1'b0;
    endtask

    initial begin
        int n;
        idle(3); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        rd_chk("R1 erased", 15'h0000, 8'hFF);
        rd_chk("R1 erased", 15'h01C5, 8'hFF);

        // single byte
        do_write(15'h0005, 8'h3C);
        wait_idle(n);
        chk("R2 busy rises on write", int'(n > 0), 1);
        chk("R4 busy length", n, LW + PC);
        rd_chk("R7 loaded byte", 15'h0005, 8'h3C);
        rd_chk("R7 neighbour kept", 15'h0004, 8'hFF);

        // page 3, out of order, maximum gaps, overwrite
        do_write(3*64 + 10, 8'hA1); idle(LW - 2);
        do_write(3*64 + 2,  8'hA2); idle(LW - 2);
        do_write(3*64 + 63, 8'hA3); idle(LW - 2);
        do_write(3*64 + 0,  8'hA4); idle(2);
        do_write(3*64 + 2,  8'h77);
        wait_idle(n);
        chk("R3 window restarted", n, LW + PC);
        rd_chk("R3 first byte", 3*64 + 10, 8'hA1);
        rd_chk("R3 last-offset byte", 3*64 + 63, 8'hA3);
        rd_chk("R6 any order", 3*64 + 0, 8'hA4);
        rd_chk("R6 overwrite", 3*64 + 2, 8'h77);
        rd_chk("R7 unloaded kept", 3*64 + 1, 8'hFF);

        // stray page during load
        do_write(5*64 + 1, 8'h11); idle(3);
        do_write(6*64 + 1, 8'h22);
        wait_idle(n);
        chk("R5 window not restarted", n, LW + PC - 5);
        rd_chk("R5 stray byte dropped", 6*64 + 1, 8'hFF);
        rd_chk("R5 good byte kept", 5*64 + 1, 8'h11);

        // one cycle past the window lands in program phase
        do_write(2*64 + 7, 8'h55); idle(LW - 1);
        do_write(2*64 + 8, 8'h66);
        wait_idle(n);
        chk("R8 late write no extension", n, LW + PC - (LW + 1));
        rd_chk("R8 late byte dropped", 2*64 + 8, 8'hFF);
        rd_chk("R8 earlier byte", 2*64 + 7, 8'h55);

        // reload one byte of page 3
        do_write(3*64 + 10, 8'h5A);
        wait_idle(n);
        rd_chk("R7 reloaded byte", 3*64 + 10, 8'h5A);
        rd_chk("R7 other byte kept", 3*64 + 63, 8'hA3);

        // page 11 maps onto array page 3
        do_write(11*64 + 0, 8'hC3);
        wait_idle(n);
        rd_chk("R9 alias write", 3*64 + 0, 8'hC3);
        rd_chk("R9 alias read", 11*64 + 63, 8'hA3);

        idle(4);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule